// File: doc/BRIEF.md
# Timer-Shared GPIO Port Controller

This block runs one general-purpose I/O port whose pins double as the output-compare outputs of a timer. Software programs a data register and a direction register over a simple register bus. Each pin also takes a compare-enable and a compare level from the timer. A pin with its compare enabled is forced to output and driven with the compare level. The direction register keeps its stored contents, and the pin returns to software control as soon as the compare is released.

Two readback paths serve software. The data readback is chosen per pin by the direction bit: it returns the stored data bit for an output and the synchronized pin level for an input. The input readback always returns the synchronized pin level. Comparing the input readback with the intended output shows a shorted or overloaded pin. A per-pin mismatch flag does this comparison in hardware.

The pin inputs pass through a two-stage synchronizer. The synchronized levels go to both readbacks and to the timer's input-capture logic. The pins are modelled as separate drive, enable and sense vectors.

Top module: `tsp_port_ctrl`

## Requirements
- R1: At address 0, bit i of a read returns the stored data bit when direction bit i is 1, and the synchronized level of pin i when direction bit i is 0. A write to address 0 loads the data register. A write to address 1 loads the direction register, and address 1 reads it back.
- R2: At address 2, a read returns the synchronized pin levels. This holds for every direction and compare setting.
- R3: When oc_en[i] is 1, pin_oe[i] is 1 and pin_out[i] equals oc_lvl[i]. Direction bit i keeps its value, and that value reads back unchanged at address 1.
- R4: When oc_en[i] is 0, pin_oe[i] equals direction bit i and pin_out[i] equals data bit i.
- R5: cap_lvl is pin_in delayed by two clock edges, with no other conditions applied, including while the pin is driven.
- R6: With oc_en[i] at 1 and direction bit i at 1, the data readback returns the stored data bit, not the compare level. With direction bit i at 0, it returns the compare level as seen through the pin.
- R7: A write to address 0 updates the data register even while a compare owns the pin. The new value appears on pin_out once the compare is released, provided the direction bit is 1.
- R8: Flag bit i is set when pin i is output-enabled and its synchronized level differs from pin_out[i] in two consecutive cycles. It clears one cycle after that condition ends. The flag is visible on pin_fault and reads at address 3.
- R9: Reset clears the data register, the direction register, the synchronizer and the flags. After reset no pin is driven unless its compare is enabled.
- R10: Writes to address 2 or address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 data, 1 direction, 2 pin input, 3 fault flags) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| oc_en | input | 8 | Per-pin compare ownership from the timer |
| oc_lvl | input | 8 | Per-pin compare level from the timer |
| pin_in | input | 8 | Sensed pin levels (asynchronous) |
| pin_out | output | 8 | Driven pin values |
| pin_oe | output | 8 | Pin output enables |
| cap_lvl | output | 8 | Synchronized pin levels to input capture |
| pin_fault | output | 8 | Per-pin drive mismatch flags |

## Verification
The bench sweeps mixed patterns in which each pin independently combines direction, compare ownership, compare level, data and external level. This catches a design that lets the direction bit override a compare, or one that clears the direction register when the compare takes the pin. It also catches a data readback that shows the compare level on output pins. The bench checks the two-edge capture latency edge by edge, so a synchronizer that is one stage short or one stage long is exposed. It also checks data writes made while a compare owns the pin, and writes to read-only addresses, so that a lost data write or an alias to the wrong register shows up. Shorted pins that are driven and shorted pins that are not driven are checked separately, which exposes a fault monitor that flags undriven pins or ignores the enable.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
   localparam int unsigned ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      REG_DATA = 2'd0,
      REG_DIR  = 2'd1,
      REG_PIN  = 2'd2,
      REG_FLT  = 2'd3
   } tsp_reg_e;
endpackage

// File: rtl/tsp_sync.sv
module tsp_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tsp_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/tsp_pin_mux.sv
module tsp_pin_mux #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] oc_en,
   input  logic [WIDTH-1:0] oc_lvl,
   input  logic [WIDTH-1:0] dir,
   input  logic [WIDTH-1:0] data,
   output logic [WIDTH-1:0] oe,
   output logic [WIDTH-1:0] out
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign oe[i]  = oc_en[i] | dir[i];
      assign out[i] = oc_en[i] ? oc_lvl[i] : data[i];
   end
endmodule

// File: rtl/tsp_fault_mon.sv
module tsp_fault_mon #(
   parameter int unsigned WIDTH   = 8,
   parameter bit          ENABLED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] oe,
   input  logic [WIDTH-1:0] out,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] flag
);
   if (ENABLED) begin : g_mon
      logic [WIDTH-1:0] diff_now;
      logic [WIDTH-1:0] diff_prev;
      logic [WIDTH-1:0] flag_q;

      assign diff_now = oe & (lvl ^ out);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            diff_prev <= '0;
            flag_q    <= '0;
         end else begin
            diff_prev <= diff_now;
            flag_q    <= diff_now & diff_prev;
         end
      end
      assign flag = flag_q;
   end else begin : g_nomon
      assign flag = '0;
   end
endmodule

// File: rtl/tsp_port_ctrl.sv
module tsp_port_ctrl #(
   parameter int unsigned WIDTH        = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          FAULT_DETECT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_sel,
   input  logic                      bus_wr,
   input  logic [tsp_pkg::ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]          bus_wdata,
   output logic [WIDTH-1:0]          bus_rdata,
   input  logic [WIDTH-1:0]          oc_en,
   input  logic [WIDTH-1:0]          oc_lvl,
   input  logic [WIDTH-1:0]          pin_in,
   output logic [WIDTH-1:0]          pin_out,
   output logic [WIDTH-1:0]          pin_oe,
   output logic [WIDTH-1:0]          cap_lvl,
   output logic [WIDTH-1:0]          pin_fault
);
   import tsp_pkg::*;

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("tsp_port_ctrl: WIDTH out of range 1..32");
   end

   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] pin_sync;
   logic             wr_data;
   logic             wr_dir;
   tsp_reg_e         sel_reg;

   assign sel_reg = tsp_reg_e'(bus_addr);
   assign wr_data = bus_sel && bus_wr && (sel_reg == REG_DATA);
   assign wr_dir  = bus_sel && bus_wr && (sel_reg == REG_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else begin
         if (wr_data) data_q <= bus_wdata;
         if (wr_dir)  dir_q  <= bus_wdata;
      end
   end

   tsp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   tsp_pin_mux #(.WIDTH(WIDTH)) u_mux (
      .oc_en  (oc_en),
      .oc_lvl (oc_lvl),
      .dir    (dir_q),
      .data   (data_q),
      .oe     (pin_oe),
      .out    (pin_out)
   );

   tsp_fault_mon #(.WIDTH(WIDTH), .ENABLED(FAULT_DETECT)) u_fault (
      .clk   (clk),
      .rst_n (rst_n),
      .oe    (pin_oe),
      .out   (pin_out),
      .lvl   (pin_sync),
      .flag  (pin_fault)
   );

   assign cap_lvl = pin_sync;

   always_comb begin
      unique case (sel_reg)
         REG_DATA: bus_rdata = (dir_q & data_q) | (~dir_q & pin_sync);
         REG_DIR:  bus_rdata = dir_q;
         REG_PIN:  bus_rdata = pin_sync;
         REG_FLT:  bus_rdata = pin_fault;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tsp_port_chk.sv
module tsp_port_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_sel,
   input logic                      bus_wr,
   input logic [tsp_pkg::ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]          bus_rdata,
   input logic [WIDTH-1:0]          oc_en,
   input logic [WIDTH-1:0]          oc_lvl,
   input logic [WIDTH-1:0]          pin_in,
   input logic [WIDTH-1:0]          pin_out,
   input logic [WIDTH-1:0]          pin_oe,
   input logic [WIDTH-1:0]          cap_lvl,
   input logic [WIDTH-1:0]          pin_fault,
   input logic [WIDTH-1:0]          dir_q
);
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   AST_OC_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & oc_en) == oc_en) && (((pin_out ^ oc_lvl) & oc_en) == '0)); // R3

   AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr && bus_addr == 2'd1) |=> $stable(dir_q)); // R3

   AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & ~oc_en & ~dir_q) == '0); // R4

   AST_CAPTURE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (cap_lvl == $past(pin_in, 2))); // R5

   AST_PIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd2) |-> (bus_rdata == cap_lvl)); // R2

   AST_FAULT_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst != 2'd0) |-> ((pin_fault & ~$past(pin_oe)) == '0)); // R8
endmodule

bind tsp_port_ctrl tsp_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .oc_en     (oc_en),
   .oc_lvl    (oc_lvl),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .cap_lvl   (cap_lvl),
   .pin_fault (pin_fault),
   .dir_q     (dir_q)
);

// File: tb/tsp_port_ctrl_test.sv
module tsp_port_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] oc_en = '0;
   logic [7:0] oc_lvl = '0;
   logic [7:0] pin_in;
   logic [7:0] pin_out;
   logic [7:0] pin_oe;
   logic [7:0] cap_lvl;
   logic [7:0] pin_fault;
   logic [7:0] ext_lvl = '0;
   logic [7:0] short_mask = '0;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign pin_in = (pin_oe & (pin_out ^ short_mask)) | (~pin_oe & ext_lvl);

   tsp_port_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .oc_en(oc_en), .oc_lvl(oc_lvl), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .cap_lvl(cap_lvl), .pin_fault(pin_fault)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      // reset state
      repeat (3) @(negedge clk);
      chk("R9 oe after reset", pin_oe, 8'h00);
      chk("R9 fault after reset", pin_fault, 8'h00);
      chk("R9 cap after reset", cap_lvl, 8'h00);
      rst_n = 1'b1;
      rd(2'd1, v); chk("R9 dir after reset", v, 8'h00);
      ext_lvl = 8'h5A; settle();
      rd(2'd0, v); chk("R9 data read of inputs", v, 8'h5A);

      // sweep of mixed per-pin configurations
      for (int k = 0; k < 48; k++) begin
         logic [7:0] dr, dt, oe_e, lv, ex, eoe, eout, epin;
         dr = 8'(k * 37 + 3); dt = 8'(k * 29 + 7);
         oe_e = 8'(k * 91 + 5); lv = 8'(k * 53 + 1); ex = 8'(k * 113 + 9);
         wr(2'd0, dt); wr(2'd1, dr);
         oc_en = oe_e; oc_lvl = lv; ext_lvl = ex;
         settle();
         eoe  = oe_e | dr;
         eout = (oe_e & lv) | (~oe_e & dt);
         epin = (eoe & eout) | (~eoe & ex);
         chk("R3/R4 pin_oe", pin_oe, eoe);
         chk("R3/R4 pin_out", pin_out, eout);
         rd(2'd0, v); chk("R1/R6 data readback", v, (dr & dt) | (~dr & epin));
         rd(2'd1, v); chk("R3 direction kept", v, dr);
         rd(2'd2, v); chk("R2 pin readback", v, epin);
         chk("R5 capture level", cap_lvl, epin);
         chk("R8 no fault without short", pin_fault, 8'h00);
      end

      // R6 explicit: compare high, dir 1 vs dir 0
      oc_en = 8'hFF; oc_lvl = 8'hF0; wr(2'd0, 8'h00); wr(2'd1, 8'hFF); settle();
      rd(2'd0, v); chk("R6 dir1 returns stored bit", v, 8'h00);
      wr(2'd1, 8'h00); settle();
      rd(2'd0, v); chk("R6 dir0 returns compare level", v, 8'hF0);

      // R7 write while owned
      wr(2'd1, 8'hFF); wr(2'd0, 8'h3C); settle();
      chk("R7 pin held by compare", pin_out, 8'hF0);
      rd(2'd0, v); chk("R7 data stored while owned", v, 8'h3C);
      oc_en = 8'h00; settle();
      chk("R7 stored value after release", pin_out, 8'h3C);
      chk("R4 oe after release", pin_oe, 8'hFF);

      // R10 read-only writes
      wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
      rd(2'd0, v); chk("R10 data unchanged", v, 8'h3C);
      rd(2'd1, v); chk("R10 dir unchanged", v, 8'hFF);
      rd(2'd2, v); chk("R10 pin read intact", v, 8'h3C);

      // R5 latency edge by edge (all inputs)
      wr(2'd1, 8'h00); ext_lvl = 8'h00; settle();
      @(negedge clk); ext_lvl = 8'hC3;
      @(negedge clk); chk("R5 one edge unchanged", cap_lvl, 8'h00);
      @(negedge clk); chk("R5 two edges updated", cap_lvl, 8'hC3);

      // R8 faults
      wr(2'd0, 8'hA5); wr(2'd1, 8'hFF); short_mask = 8'h0F; settle();
      chk("R8 driven shorts flagged", pin_fault, 8'h0F);
      rd(2'd3, v); chk("R8 flag register", v, 8'h0F);
      rd(2'd2, v); chk("R8 pin read shows short", v, 8'hAA);
      wr(2'd1, 8'hF0); short_mask = 8'hFF; settle();
      chk("R8 only driven pins flag", pin_fault, 8'hF0);
      short_mask = 8'h00; settle();
      chk("R8 flag clears", pin_fault, 8'h00);

      // R9 reset again
      rst_n = 1'b0; #1;
      chk("R9 oe in reset", pin_oe, 8'h00);
      chk("R9 out in reset", pin_out, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule